// File: doc/BRIEF.md
# Keyed Byte Store Controller

This block is a register-mapped controller for a small byte-wide nonvolatile store. The store itself is held as flops inside the block. A CPU reaches it over a simple register bus with four registers: a data register, an address register, a control/status register and a key register that can only be written. A read is a single step. Software loads the address and sets the read bit, and the addressed byte is in the data register straight after that edge.

A write has two guards so that code running astray cannot change the store. Software first sets a write-enable bit. It then writes 55h followed by AAh to the key register and sets the write bit. The programming time is a parameterised count of cycles. At the end of that count the hardware drops the write bit and raises a completion flag. The flag stays set until software clears it, and it is also brought out as an interrupt request.

A warm reset input ends any write in flight. It records that the write was lost in an error bit. It leaves the store, the data register and the address register as they were.

Top module: `nvbyte_ctrl`

## Requirements
- R1: A control write with bit 0 (read) set, while no write is in progress, loads the data register from the addressed byte at that same edge. Bit 0 then reads 1 for exactly one cycle and clears itself.
- R2: After a read, the data register keeps its value through writes to other registers. It changes only on another read or on a bus write to the data register.
- R3: A write starts only on this exact series of bus writes: 55h to the key register, then AAh to the key register, then a control write with bit 1 (write) set. Any other bus write in between breaks the series, including a wrong key value and a write to another register. Each series starts at most one write.
- R4: Bit 1 can only be set when bit 2 (write enable) was already 1 before that bus write. The hardware never clears bit 2; only software and the resets do.
- R5: Bit 1 reads 1 for exactly WR_CYCLES edges after the starting edge. At the last of those edges bit 1 clears, bit 4 (completion flag) sets and the staged byte is stored. Clearing bit 2 while the write runs does not change any of this.
- R6: Bit 4 and `done_irq` stay set until a control write with bit 4 at 0. A control write cannot set bit 4.
- R7: Register select encoding: 0 data, 1 address, 2 control, 3 key. The control register reads {000, flag, error, enable, write, read} from bit 7 down to bit 0. The key register always reads 0.
- R8: While a write is in progress, read requests and bus writes to the address and data registers are ignored.
- R9: Power-on reset clears all registers and the store. A warm reset clears bits 0, 1, 2 and 4 and abandons any running write without storing it. It sets bit 3 (error) exactly when a write was running, and it keeps the store, the data register and the address register.
- R10: Address bits at and above log2(DEPTH) are ignored when the store is accessed, so an address and its alias reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst_n | input | 1 | Synchronous warm reset, active low |
| bus_we | input | 1 | Bus write strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Read data of the selected register |
| done_irq | output | 1 | Completion flag, used as interrupt request |

## Verification
The key series is driven in the correct order, in reversed order, with a wrong key value in the middle, with a data-register write in the middle, and again without fresh keys after a completed write. Telling a refused start apart from an accepted one relies on bit 1 being clear straight after the control write. The write enable is tried both already set and set in the same bus write as bit 1, which shows whether the "already" condition is respected. Completed writes are checked at the exact cycle count, with the enable cleared part way through, and through an aliased address. A warm reset in mid-write is compared against a warm reset when no write is running, which separates a lost write from an idle one.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
    localparam int DW = 8;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_KEY  = 2'd3
    } reg_sel_e;

    localparam logic [DW-1:0] KEY_FIRST  = 8'h55;
    localparam logic [DW-1:0] KEY_SECOND = 8'hAA;

    localparam int B_RD    = 0;
    localparam int B_WR    = 1;
    localparam int B_WREN  = 2;
    localparam int B_WRERR = 3;
    localparam int B_DONE  = 4;

    typedef enum logic [1:0] {
        UL_IDLE,
        UL_HALF,
        UL_ARMED
    } unlock_e;

    typedef struct packed {
        logic [DW-1:0] data;
        logic [DW-1:0] addr;
        logic          done;
        logic          wrerr;
        logic          wren;
        logic          rd;
    } regs_t;
endpackage

// File: rtl/nvb_unlock.sv
module nvb_unlock
    import nvb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          bus_we,
    input  logic [1:0]    bus_sel,
    input  logic [DW-1:0] bus_wdata,
    output logic          armed
);
    unlock_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = UL_IDLE;
        end else if (bus_we) begin
            if (bus_sel == SEL_KEY) begin
                if (bus_wdata == KEY_FIRST)
                    st_d = UL_HALF;
                else if (bus_wdata == KEY_SECOND && st_q == UL_HALF)
                    st_d = UL_ARMED;
                else
                    st_d = UL_IDLE;
            end else begin
                // any other register write, including the arming control write, ends the series
                st_d = UL_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= UL_IDLE;
        else        st_q <= st_d;
    end

    assign armed = (st_q == UL_ARMED);
endmodule

// File: rtl/nvb_timer.sv
module nvb_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (start && cnt_q == '0)
            cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1)) && !clr;
endmodule

// File: rtl/nvb_array.sv
module nvb_array
    import nvb_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cell_vec [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [DW-1:0] byte_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                byte_q <= '0;
            else if (we && waddr == AW'(g))
                byte_q <= wdata;
        end
        assign cell_vec[g] = byte_q;
    end

    assign rdata = cell_vec[raddr];
endmodule

// File: rtl/nvbyte_ctrl.sv
module nvbyte_ctrl
    import nvb_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int WR_CYCLES = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst_n,
    input  logic          bus_we,
    input  logic [1:0]    bus_sel,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          done_irq
);
    localparam int AW = $clog2(DEPTH);

    regs_t         r_q, r_d;
    logic          armed;
    logic          wr_busy;
    logic          wr_done;
    logic          wr_start;
    logic          clr;
    logic          ctrl_wr;
    logic [DW-1:0] cell_rd;

    assign clr     = !soft_rst_n;
    assign ctrl_wr = bus_we && (bus_sel == SEL_CTRL);
    // enable must already be set; the key series must be complete
    assign wr_start = ctrl_wr && soft_rst_n && bus_wdata[B_WR]
                      && r_q.wren && armed && !wr_busy;

    nvb_unlock u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .bus_we    (bus_we),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .armed     (armed)
    );

    nvb_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .start (wr_start),
        .busy  (wr_busy),
        .done  (wr_done)
    );

    nvb_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_done),
        .waddr (r_q.addr[AW-1:0]),
        .wdata (r_q.data),
        .raddr (r_q.addr[AW-1:0]),
        .rdata (cell_rd)
    );

    always_comb begin
        r_d    = r_q;
        r_d.rd = 1'b0;
        if (!soft_rst_n) begin
            r_d.wren  = 1'b0;
            r_d.done  = 1'b0;
            r_d.wrerr = wr_busy;
        end else begin
            if (bus_we) begin
                case (bus_sel)
                    SEL_DATA: if (!wr_busy) r_d.data = bus_wdata;
                    SEL_ADDR: if (!wr_busy) r_d.addr = bus_wdata;
                    SEL_CTRL: begin
                        r_d.wren  = bus_wdata[B_WREN];
                        r_d.wrerr = r_q.wrerr & bus_wdata[B_WRERR];
                        r_d.done  = r_q.done & bus_wdata[B_DONE];
                        if (bus_wdata[B_RD] && !wr_busy) begin
                            r_d.rd   = 1'b1;
                            r_d.data = cell_rd;
                        end
                    end
                    default: ;
                endcase
            end
            if (wr_done) r_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (bus_sel)
            SEL_DATA: bus_rdata = r_q.data;
            SEL_ADDR: bus_rdata = r_q.addr;
            SEL_CTRL: bus_rdata = {3'b000, r_q.done, r_q.wrerr, r_q.wren, wr_busy, r_q.rd};
            default:  bus_rdata = '0;
        endcase
    end

    assign done_irq = r_q.done;
endmodule

// File: rtl/nvb_chk.sv
module nvb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst_n,
    input logic       bus_we,
    input logic [1:0] bus_sel,
    input logic [7:0] bus_rdata,
    input logic       done_irq,
    input logic       armed,
    input logic       wr_busy,
    input logic       wren,
    input logic [7:0] addr
);
    // R7
    ctrl_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel == 2'd2 |-> bus_rdata[7:5] == 3'b000);

    // R7
    key_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel == 2'd3 |-> bus_rdata == 8'h00);

    // R3
    start_needs_keys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy) |-> $past(armed));

    // R4
    start_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy) |-> $past(wren));

    // R4
    enable_not_hw_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wren && soft_rst_n && !(bus_we && bus_sel == 2'd2) |=> wren);

    // R5
    finish_raises_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_busy) && $past(soft_rst_n) |-> done_irq);

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq && soft_rst_n && !(bus_we && bus_sel == 2'd2) |=> done_irq);

    // R8
    addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy && bus_we && bus_sel == 2'd1 |=> $stable(addr));
endmodule

bind nvbyte_ctrl nvb_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst_n (soft_rst_n),
    .bus_we     (bus_we),
    .bus_sel    (bus_sel),
    .bus_rdata  (bus_rdata),
    .done_irq   (done_irq),
    .armed      (armed),
    .wr_busy    (wr_busy),
    .wren       (r_q.wren),
    .addr       (r_q.addr)
);

// File: tb/sim_nvbyte_ctrl.sv
module sim_nvbyte_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCYC       = 12;
    localparam logic [1:0] S_DATA = 2'd0, S_ADDR = 2'd1, S_CTRL = 2'd2, S_KEY = 2'd3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst_n = 1'b1;
    logic       bus_we = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       done_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    logic [7:0] q_exp [$];
    string      q_tag [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nvbyte_ctrl #(.DEPTH(64), .WR_CYCLES(NCYC)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst_n (soft_rst_n),
        .bus_we     (bus_we),
        .bus_sel    (bus_sel),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .done_irq   (done_irq)
    );

    // monitor: pops expected items and compares them with the read port
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q_exp.size() > 0) begin
                logic [7:0] e;
                string      t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                n_tests++;
                if (bus_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: got %02h expected %02h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        bus_we = 1'b1; bus_sel = sel; bus_wdata = val;
        @(posedge clk);
        #1;
        bus_we = 1'b0;
    endtask

    task automatic chk(input logic [1:0] sel, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_we = 1'b0; bus_sel = sel;
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        #2;
    endtask

    task automatic chk_bit(input logic act, input logic exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    // stage and fire one keyed write; returns right after the starting edge
    task automatic start_write(input logic [7:0] a, input logic [7:0] d);
        wr(S_ADDR, a);
        wr(S_DATA, d);
        wr(S_CTRL, 8'h04);
        wr(S_KEY, 8'h55);
        wr(S_KEY, 8'hAA);
        wr(S_CTRL, 8'h06);
    endtask

    task automatic read_at(input logic [7:0] a);
        wr(S_ADDR, a);
        wr(S_CTRL, 8'h01);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9 power-on state, R7 key reads zero
        chk(S_CTRL, 8'h00, "R9 ctrl after power-on");
        chk(S_KEY,  8'h00, "R7 key reads zero");
        chk(S_DATA, 8'h00, "R9 data after power-on");

        // R1 read of blank store, RD one cycle
        read_at(8'h03);
        chk(S_CTRL, 8'h01, "R1 rd bit high one cycle");
        chk(S_CTRL, 8'h00, "R1 rd bit self-cleared");
        chk(S_DATA, 8'h00, "R1 blank byte");

        // R8 busy ignores address, data and RD
        start_write(8'h03, 8'h5A);
        chk(S_CTRL, 8'h06, "R5 busy after start");
        wr(S_ADDR, 8'h33);
        wr(S_DATA, 8'h11);
        wr(S_CTRL, 8'h05);
        chk(S_ADDR, 8'h03, "R8 addr write ignored");
        chk(S_DATA, 8'h5A, "R8 data write and rd ignored");
        repeat (NCYC + 2) @(posedge clk);
        chk(S_CTRL, 8'h14, "R5 flag set, wr cleared, R4 wren kept");
        chk_bit(done_irq, 1'b1, "R6 irq output high");
        wr(S_ADDR, 8'h03);
        repeat (4) @(posedge clk);
        chk(S_CTRL, 8'h14, "R6 flag stays set");
        wr(S_CTRL, 8'h04);
        chk(S_CTRL, 8'h04, "R6 flag cleared by software");
        chk_bit(done_irq, 1'b0, "R6 irq output low");
        wr(S_CTRL, 8'h01);
        chk(S_DATA, 8'h5A, "R1 stored byte read back");

        // R2 data register holds after read
        wr(S_ADDR, 8'h20);
        wr(S_CTRL, 8'h00);
        chk(S_DATA, 8'h5A, "R2 data held");

        // R5 exact timing with enable cleared mid-write
        start_write(8'h07, 8'hC3);
        wr(S_CTRL, 8'h00);
        repeat (NCYC - 2) @(posedge clk);
        chk(S_CTRL, 8'h02, "R5 still busy at last cycle");
        @(posedge clk);
        chk(S_CTRL, 8'h10, "R5 done after WR_CYCLES");
        read_at(8'h07);
        chk(S_DATA, 8'hC3, "R5 write survived enable clear");

        // R3 keys are consumed per byte
        wr(S_CTRL, 8'h04);
        wr(S_CTRL, 8'h06);
        chk(S_CTRL, 8'h04, "R3 no start without fresh keys");

        // R3 reversed keys
        wr(S_ADDR, 8'h09);
        wr(S_DATA, 8'h77);
        wr(S_KEY, 8'hAA);
        wr(S_KEY, 8'h55);
        wr(S_CTRL, 8'h06);
        chk(S_CTRL, 8'h04, "R3 reversed keys refused");

        // R3 interrupted by data write
        wr(S_KEY, 8'h55);
        wr(S_DATA, 8'h77);
        wr(S_KEY, 8'hAA);
        wr(S_CTRL, 8'h06);
        chk(S_CTRL, 8'h04, "R3 interrupted series refused");

        // R3 wrong key value in the middle
        wr(S_KEY, 8'h55);
        wr(S_KEY, 8'h12);
        wr(S_KEY, 8'hAA);
        wr(S_CTRL, 8'h06);
        chk(S_CTRL, 8'h04, "R3 wrong key refused");
        repeat (NCYC + 2) @(posedge clk);
        read_at(8'h09);
        chk(S_DATA, 8'h00, "R3 store untouched");

        // R4 enable set in the same write as WR
        wr(S_ADDR, 8'h09);
        wr(S_CTRL, 8'h00);
        wr(S_KEY, 8'h55);
        wr(S_KEY, 8'hAA);
        wr(S_CTRL, 8'h06);
        chk(S_CTRL, 8'h04, "R4 enable not already set");
        chk_bit(done_irq, 1'b0, "R4 no completion");

        // R10 address alias
        start_write(8'h45, 8'h9E);
        repeat (NCYC + 1) @(posedge clk);
        read_at(8'h05);
        chk(S_DATA, 8'h9E, "R10 alias reaches same byte");

        // R9 warm reset mid-write
        start_write(8'h0A, 8'hEE);
        repeat (3) @(posedge clk);
        @(negedge clk);
        soft_rst_n = 1'b0;
        @(posedge clk);
        #1 soft_rst_n = 1'b1;
        chk(S_CTRL, 8'h08, "R9 error bit after lost write");
        chk(S_DATA, 8'hEE, "R9 data kept over warm reset");
        chk(S_ADDR, 8'h0A, "R9 addr kept over warm reset");
        repeat (NCYC + 1) @(posedge clk);
        wr(S_CTRL, 8'h01);
        chk(S_DATA, 8'h00, "R9 abandoned write not stored");
        read_at(8'h07);
        chk(S_DATA, 8'hC3, "R9 store kept over warm reset");

        // R9 warm reset when idle
        @(negedge clk);
        soft_rst_n = 1'b0;
        @(posedge clk);
        #1 soft_rst_n = 1'b1;
        chk(S_CTRL, 8'h00, "R9 no error when idle");

        // R9 power-on reset clears the store
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        chk(S_CTRL, 8'h00, "R9 ctrl after second power-on");
        read_at(8'h07);
        chk(S_DATA, 8'h00, "R9 store cleared by power-on");

        repeat (3) @(posedge clk);
        summary();
    end
endmodule